// File: doc/BRIEF.md
# Write-and-Invalidate Command Segmenter

This block sits on the master side of a destination bus and drains posted memory-write bursts. The posting buffer delivers one doubleword per beat, with byte enables, an address, a linear-ordering flag and an end-of-burst marker. The block cuts each burst at cacheline boundaries and picks a bus command for every piece. A cacheline that starts on a line boundary, is fully present in the burst and has every byte enabled on every beat goes out as write-and-invalidate. Every other piece goes out as a plain memory write. Pieces that share a command and follow each other in the same burst are merged into one transaction. A new transaction starts wherever the command changes.

Two event inputs are sampled with each accepted output beat. The first reports that the target disconnected after that beat. The second reports that the master latency timer expired. After a disconnect, the unfinished part of the interrupted cacheline is resumed as a plain write, and later whole lines are promoted again. When the latency timer expires inside a write-and-invalidate transaction, the transaction ends only at the next line boundary. Data, byte enables and addresses always leave the block in the order they arrived.

Top module: `wr_inv_segmenter`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Output beats carry the input data, byte enables and addresses in arrival order. While `out_valid` is high and `out_ready` is low, the beat is held stable. Within one transaction, addresses increase by one.
- R3: `out_cmd` is 1 for write-and-invalidate and 0 for a plain write. It can be 1 only if `cfg_promote_en` is 1, `cfg_line_size` is a power of two from 2 to MAX_LINE, and every beat of the line had `in_linear` set. Otherwise every beat is 0.
- R4: A line is promoted only if it starts at an address whose low bits (address modulo line size) are zero, all of its beats belong to the same burst, and `in_be` is all ones on each of them. A line with any cleared enable goes out with command 0.
- R5: A burst that is unaligned at both ends and spans whole lines is issued as three transactions in order: a plain head up to the first boundary, write-and-invalidate for the whole lines, and a plain tail.
- R6: `out_start` is 1 on the first beat of each burst and on any beat whose command differs from the previous beat.
- R7: A disconnect on a beat that is not the last beat of its line makes the remaining beats of that line go out with command 0 in a new transaction. Later whole lines are promoted again.
- R8: A burst that ends before its last line is complete sends that line with command 0. Complete lines before it keep command 1.
- R9: A latency expiry on a write-and-invalidate beat starts a new transaction at the next line boundary and no earlier.
- R10: A latency expiry on a plain-write beat starts a new transaction on the very next beat.
- R11: A disconnect on the last beat of a line starts a new transaction at the next beat. That beat keeps its promoted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_line_size | input | CLS_W | Cacheline size in doublewords; stable while traffic is in flight |
| cfg_promote_en | input | 1 | Enable for promotion to write-and-invalidate |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with in_valid |
| in_addr | input | ADDR_W | Doubleword address of the input beat |
| in_data | input | DATA_W | Write data |
| in_be | input | DATA_W/8 | Byte enables, 1 = byte written |
| in_last | input | 1 | Last beat of a burst |
| in_linear | input | 1 | Burst uses linear incrementing ordering |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Destination accepts the output beat |
| out_start | output | 1 | Beat opens a new transaction |
| out_cmd | output | 1 | 0 = memory write, 1 = write-and-invalidate |
| out_addr | output | ADDR_W | Doubleword address of the output beat |
| out_data | output | DATA_W | Output data |
| out_be | output | DATA_W/8 | Output byte enables |
| tgt_disc | input | 1 | Target disconnected after the beat being accepted |
| lat_exp | input | 1 | Latency timer expired at the beat being accepted |

## Verification
The hardest case to reach is a disconnect or latency expiry that lands on a chosen beat inside a promoted line while the destination is also stalling. Both effects depend on where that beat sits within its line and on what the block has already loaded into its output register. The bench drives the event inputs from the same process that drives `out_ready`. It fires them either on an exact address (the line's last beat versus a middle beat) or at random on accepted beats. The monitor carries its own model of pending breaks and demoted lines. This lets it predict the command and start flag of every beat, across random stalls, line sizes, enable holes and burst alignments.

// File: rtl/wis_pkg.sv
package wis_pkg;
  typedef enum logic {
    CMD_MW  = 1'b0,
    CMD_MWI = 1'b1
  } wcmd_t;
endpackage

// File: rtl/wis_line_size.sv
// Decodes the configured line size: legal values are powers of two from 2
// up to MAX_LINE. Produces the in-line offset mask used for boundaries.
module wis_line_size #(
  parameter int CLS_W    = 8,
  parameter int MAX_LINE = 16,
  localparam int IW      = $clog2(MAX_LINE)
) (
  input  logic [CLS_W-1:0] line_size,
  input  logic             promote_en,
  output logic             size_ok,
  output logic             promote_ok,
  output logic [IW-1:0]    line_mask
);
  logic [IW-1:0] hit;

  generate
    for (genvar k = 1; k <= IW; k++) begin : g_pow
      assign hit[k-1] = (line_size == CLS_W'(1 << k));
    end
  endgenerate

  assign size_ok    = |hit;
  assign promote_ok = promote_en && size_ok;
  assign line_mask  = size_ok ? IW'(line_size - 1'b1) : '0;
endmodule

// File: rtl/wis_collect.sv
// Gathers one line segment (from the burst start or a line boundary up to the
// next boundary or burst end) into a small line buffer and classifies it.
module wis_collect #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int MAX_LINE = 16,
  localparam int BE_W    = DATA_W / 8,
  localparam int IW      = $clog2(MAX_LINE),
  localparam int LW      = IW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic [BE_W-1:0]   in_be,
  input  logic              in_last,
  input  logic              in_linear,
  input  logic              promote_ok,
  input  logic [IW-1:0]     line_mask,
  input  logic [IW-1:0]     rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [BE_W-1:0]   rd_be,
  output logic              seg_rdy,
  output logic [ADDR_W-1:0] seg_addr,
  output logic [LW-1:0]     seg_len,
  output logic              seg_mwi,
  output logic              seg_newburst,
  input  logic              release_seg
);
  logic [BE_W+DATA_W-1:0] line_buf [MAX_LINE];
  logic                   hold;
  logic [IW-1:0]          wcnt;
  logic                   be_run, lin_run, algn_run, bstart;
  logic [ADDR_W-1:0]      s_addr;

  logic          acc, first_beat, line_end, cap, seg_end;
  logic          be_now, lin_now, algn_now;
  logic [IW-1:0] lo;

  assign in_ready   = !hold;
  assign seg_rdy    = hold;
  assign seg_addr   = s_addr;
  assign acc        = in_valid && !hold;
  assign first_beat = (wcnt == '0);
  assign lo         = in_addr[IW-1:0];
  assign line_end   = ((lo & line_mask) == line_mask);
  assign cap        = (wcnt == IW'(MAX_LINE - 1));
  assign seg_end    = in_last || line_end || cap;
  assign be_now     = (first_beat || be_run) && (&in_be);
  assign lin_now    = (first_beat || lin_run) && in_linear;
  assign algn_now   = first_beat ? ((lo & line_mask) == '0) : algn_run;

  // line buffer: write port only, no reset, so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (acc) line_buf[wcnt] <= {in_be, in_data};
  end

  assign {rd_be, rd_data} = line_buf[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      hold         <= 1'b0;
      wcnt         <= '0;
      be_run       <= 1'b0;
      lin_run      <= 1'b0;
      algn_run     <= 1'b0;
      bstart       <= 1'b1;
      s_addr       <= '0;
      seg_len      <= '0;
      seg_mwi      <= 1'b0;
      seg_newburst <= 1'b0;
    end else begin
      if (release_seg) hold <= 1'b0;
      if (acc) begin
        be_run   <= be_now;
        lin_run  <= lin_now;
        algn_run <= algn_now;
        if (first_beat) s_addr <= in_addr;
        if (seg_end) begin
          hold         <= 1'b1;
          wcnt         <= '0;
          seg_len      <= LW'(wcnt) + 1'b1;
          // aligned start plus ending on the line's last offset = whole line
          seg_mwi      <= promote_ok && be_now && lin_now && algn_now && line_end;
          seg_newburst <= bstart;
          bstart       <= in_last;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wis_emit.sv
// Streams a classified segment onto the registered output, applying
// disconnect demotion, latency breaks and transaction-start decisions.
module wis_emit
  import wis_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int MAX_LINE = 16,
  localparam int BE_W    = DATA_W / 8,
  localparam int IW      = $clog2(MAX_LINE),
  localparam int LW      = IW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seg_rdy,
  input  logic [ADDR_W-1:0] seg_addr,
  input  logic [LW-1:0]     seg_len,
  input  logic              seg_mwi,
  input  logic              seg_newburst,
  output logic [IW-1:0]     rd_idx,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [BE_W-1:0]   rd_be,
  output logic              release_seg,
  input  logic              out_ready,
  input  logic              tgt_disc,
  input  logic              lat_exp,
  output logic              out_valid,
  output logic              out_start,
  output logic              out_cmd,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic [BE_W-1:0]   out_be
);
  logic          active, demote, brk, lpend;
  logic [LW-1:0] rd;
  wcmd_t         cur_cmd, last_cmd, ld_cmd;

  logic hs, adv, load, first, disc_now, lat_mw, lat_mwi;
  logic mid_disc, dem_eff, lp_eff, ld_start, ld_final;

  assign hs       = out_valid && out_ready;
  assign disc_now = hs && tgt_disc;
  assign lat_mw   = hs && lat_exp && (cur_cmd == CMD_MW);
  assign lat_mwi  = hs && lat_exp && (cur_cmd == CMD_MWI);
  assign adv      = !out_valid || out_ready;
  assign load     = active && adv;
  assign first    = (rd == '0);
  // disconnect on a beat of this segment that still has beats behind it
  assign mid_disc = disc_now && active && !first;
  assign dem_eff  = demote || mid_disc;
  assign ld_cmd   = (seg_mwi && !dem_eff) ? CMD_MWI : CMD_MW;
  assign lp_eff   = lpend || lat_mwi;
  assign ld_start = brk || disc_now || lat_mw ||
                    (first && (seg_newburst || lp_eff)) ||
                    (ld_cmd != last_cmd);
  assign ld_final    = ((rd + 1'b1) == seg_len);
  assign release_seg = load && ld_final;
  assign rd_idx      = rd[IW-1:0];
  assign out_cmd     = cur_cmd;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      rd        <= '0;
      demote    <= 1'b0;
      brk       <= 1'b0;
      lpend     <= 1'b0;
      last_cmd  <= CMD_MW;
      cur_cmd   <= CMD_MW;
      out_valid <= 1'b0;
      out_start <= 1'b0;
      out_addr  <= '0;
      out_data  <= '0;
      out_be    <= '0;
    end else begin
      if (!active && seg_rdy) begin
        active <= 1'b1;
        rd     <= '0;
        demote <= 1'b0;
      end
      if (load) begin
        out_valid <= 1'b1;
        out_start <= ld_start;
        cur_cmd   <= ld_cmd;
        out_addr  <= seg_addr + ADDR_W'(rd);
        out_data  <= rd_data;
        out_be    <= rd_be;
        rd        <= rd + 1'b1;
        last_cmd  <= ld_cmd;
        brk       <= 1'b0;
        lpend     <= first ? 1'b0 : lp_eff;
        demote    <= dem_eff;
        if (ld_final) active <= 1'b0;
      end else begin
        if (hs) out_valid <= 1'b0;
        brk   <= brk || disc_now || lat_mw;
        lpend <= lp_eff;
        if (mid_disc) demote <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wr_inv_segmenter.sv
module wr_inv_segmenter #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int MAX_LINE = 16,
  parameter int CLS_W    = 8,
  localparam int BE_W    = DATA_W / 8,
  localparam int IW      = $clog2(MAX_LINE),
  localparam int LW      = IW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CLS_W-1:0]  cfg_line_size,
  input  logic              cfg_promote_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic [BE_W-1:0]   in_be,
  input  logic              in_last,
  input  logic              in_linear,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_start,
  output logic              out_cmd,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic [BE_W-1:0]   out_be,
  input  logic              tgt_disc,
  input  logic              lat_exp
);
  logic              size_ok, promote_ok;
  logic [IW-1:0]     line_mask, rd_idx;
  logic [DATA_W-1:0] rd_data;
  logic [BE_W-1:0]   rd_be;
  logic              seg_rdy, seg_mwi, seg_newburst, release_seg;
  logic [ADDR_W-1:0] seg_addr;
  logic [LW-1:0]     seg_len;

  wis_line_size #(.CLS_W(CLS_W), .MAX_LINE(MAX_LINE)) i_size (
    .line_size  (cfg_line_size),
    .promote_en (cfg_promote_en),
    .size_ok    (size_ok),
    .promote_ok (promote_ok),
    .line_mask  (line_mask)
  );

  wis_collect #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_LINE(MAX_LINE)) i_collect (
    .clk, .rst,
    .in_valid, .in_ready, .in_addr, .in_data, .in_be, .in_last, .in_linear,
    .promote_ok, .line_mask,
    .rd_idx, .rd_data, .rd_be,
    .seg_rdy, .seg_addr, .seg_len, .seg_mwi, .seg_newburst,
    .release_seg
  );

  wis_emit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_LINE(MAX_LINE)) i_emit (
    .clk, .rst,
    .seg_rdy, .seg_addr, .seg_len, .seg_mwi, .seg_newburst,
    .rd_idx, .rd_data, .rd_be,
    .release_seg,
    .out_ready, .tgt_disc, .lat_exp,
    .out_valid, .out_start, .out_cmd, .out_addr, .out_data, .out_be
  );
endmodule

// File: rtl/wr_inv_segmenter_chk.sv
module wr_inv_segmenter_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CLS_W  = 8,
  localparam int BE_W  = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic [CLS_W-1:0]  cfg_line_size,
  input logic              cfg_promote_en,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_start,
  input logic              out_cmd,
  input logic [ADDR_W-1:0] out_addr,
  input logic [DATA_W-1:0] out_data,
  input logic [BE_W-1:0]   out_be
);
  logic [ADDR_W-1:0] prev_addr;
  logic              have_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_addr <= '0;
      have_prev <= 1'b0;
    end else if (out_valid && out_ready) begin
      prev_addr <= out_addr;
      have_prev <= 1'b1;
    end
  end

  // R2: a stalled beat does not change
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) &&
      $stable(out_data) && $stable(out_cmd) && $stable(out_start));

  // R2: addresses inside one transaction are consecutive
  a_r2_addr_contig: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_start && have_prev |-> out_addr == prev_addr + 1'b1);

  // R3: promotion only when enabled
  a_r3_needs_enable: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_cmd |-> cfg_promote_en);

  // R4: promoted beats carry all byte enables
  a_r4_full_enables: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_cmd |-> &out_be);

  // R4: a promoted transaction opens on a line boundary
  a_r4_start_aligned: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_start && out_cmd |->
      (out_addr & (ADDR_W'(cfg_line_size) - 1'b1)) == '0);
endmodule

bind wr_inv_segmenter wr_inv_segmenter_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLS_W(CLS_W)
) i_chk (
  .clk(clk), .rst(rst),
  .cfg_line_size(cfg_line_size), .cfg_promote_en(cfg_promote_en),
  .out_valid(out_valid), .out_ready(out_ready), .out_start(out_start),
  .out_cmd(out_cmd), .out_addr(out_addr), .out_data(out_data), .out_be(out_be)
);

// File: tb/test_wr_inv_segmenter.sv
`timescale 1ns/1ps
module test_wr_inv_segmenter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cls = 8'd8;
  logic        en  = 1'b1;
  logic        in_valid = 1'b0, in_last = 1'b0, in_linear = 1'b1;
  logic        in_ready;
  logic [31:0] in_addr = '0, in_data = '0;
  logic [3:0]  in_be = '0;
  logic        out_valid, out_start, out_cmd;
  logic        out_ready = 1'b0, tgt_disc = 1'b0, lat_exp = 1'b0;
  logic [31:0] out_addr, out_data;
  logic [3:0]  out_be;

  always #2.5 clk = ~clk;

  wr_inv_segmenter i_wr_inv_segmenter (
    .clk, .rst, .cfg_line_size(cls), .cfg_promote_en(en),
    .in_valid, .in_ready, .in_addr, .in_data, .in_be, .in_last, .in_linear,
    .out_valid, .out_ready, .out_start, .out_cmd, .out_addr, .out_data, .out_be,
    .tgt_disc, .lat_exp
  );

  typedef struct {
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  be;
    bit          cmd;
    bit          lfirst;
    bit          llast;
    bit          bfirst;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0, errors = 0, cyc = 0, scen_starts = 0;
  bit   finished = 0;

  // event control: random, or fire on one exact address
  bit          rand_ev = 0, disc_on = 0, lat_on = 0;
  logic [31:0] disc_at = '0, lat_at = '0;

  // monitor-side model state
  bit m_brk = 0, m_lpend = 0, m_dem = 0, m_prev = 0, cur_cmd_m = 0, cur_last_m = 0;
  bit checked = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  function automatic bit size_legal(input logic [7:0] s);
    return (s == 8'd2 || s == 8'd4 || s == 8'd8 || s == 8'd16);
  endfunction

  task automatic send(input logic [31:0] a0, input int n, input int hole,
                      input bit lin, input string tag);
    int L;
    bit ok;
    ok = size_legal(cls);
    L  = ok ? int'(cls) : 1;
    for (int i = 0; i < n; i++) begin
      exp_t e;
      logic [31:0] a;
      int off, bi;
      a   = a0 + 32'(i);
      off = int'(a % 32'(L));
      bi  = i - off;
      e.addr   = a;
      e.data   = {a[15:0], 16'(i) ^ 16'h5A3C};
      e.be     = (i == hole) ? 4'hE : 4'hF;
      e.cmd    = en && ok && lin && (bi >= 0) && (bi + L <= n) &&
                 !(hole >= bi && hole < bi + L);
      e.lfirst = (off == 0) || (i == 0);
      e.llast  = (off == L - 1) || (i == n - 1);
      e.bfirst = (i == 0);
      e.tag    = tag;
      q.push_back(e);
    end
    for (int i = 0; i < n; i++) begin
      logic [31:0] a;
      a = a0 + 32'(i);
      in_valid  = 1'b1;
      in_addr   = a;
      in_data   = {a[15:0], 16'(i) ^ 16'h5A3C};
      in_be     = (i == hole) ? 4'hE : 4'hF;
      in_last   = (i == n - 1);
      in_linear = lin;
      while (1) begin
        if (in_ready) begin
          @(negedge clk);
          break;
        end
        @(negedge clk);
      end
      in_valid = 1'b0;
      if (rand_ev && $urandom_range(0, 99) < 20) @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0 || out_valid) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // monitor / scoreboard and destination-side stimulus
  always @(negedge clk) begin
    if (!rst) begin
      bit rdy, dv, lv, ec, es;
      if (out_valid && !checked) begin
        if (q.size() == 0) begin
          check(0, "R2", "unexpected beat addr", int'(out_addr), -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (e.lfirst) m_dem = 0;
          ec = m_dem ? 1'b0 : e.cmd;
          es = e.bfirst || m_brk || (e.lfirst && m_lpend) || (ec != m_prev);
          m_brk = 0;
          if (e.lfirst) m_lpend = 0;
          m_prev = ec;
          checks++;
          if (out_addr !== e.addr || out_data !== e.data || out_be !== e.be ||
              out_cmd !== ec || out_start !== es) begin
            errors++;
            $display("FAIL %s beat actual addr=%h data=%h be=%h cmd=%0d start=%0d expected addr=%h data=%h be=%h cmd=%0d start=%0d",
                     e.tag, out_addr, out_data, out_be, out_cmd, out_start,
                     e.addr, e.data, e.be, ec, es);
          end
          if (out_start) scen_starts++;
          cur_cmd_m  = ec;
          cur_last_m = e.llast;
        end
        checked = 1;
      end
      rdy = ($urandom_range(0, 99) < 70);
      dv = 0;
      lv = 0;
      if (out_valid && rdy) begin
        if (rand_ev) begin
          dv = ($urandom_range(0, 99) < 8);
          lv = ($urandom_range(0, 99) < 8);
        end else begin
          dv = disc_on && (out_addr == disc_at);
          lv = lat_on && (out_addr == lat_at);
        end
        m_brk = dv || (lv && !cur_cmd_m);
        if (lv && cur_cmd_m) begin
          if (cur_last_m) m_brk = 1;
          else m_lpend = 1;
        end
        if (dv && !cur_last_m) m_dem = 1;
        checked = 0;
      end
      out_ready = rdy;
      tgt_disc  = dv;
      lat_exp   = lv;
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  task automatic scen(input logic [31:0] a0, input int n, input int hole,
                      input bit lin, input string tag, input int exp_starts);
    scen_starts = 0;
    send(a0, n, hole, lin, tag);
    drain();
    check(scen_starts == exp_starts, tag, "transaction count", scen_starts, exp_starts);
    disc_on = 0;
    lat_on  = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

    cls = 8'd8; en = 1'b1;
    // R5: head 0x103..0x107, lines 0x108 and 0x110, tail 0x118..0x11A
    scen(32'h103, 24, -1, 1, "R5", 3);
    // R4: hole in the second line demotes that line only
    scen(32'h200, 16, 10, 1, "R4", 2);
    // R6: fully aligned promoted burst is a single transaction
    scen(32'h240, 16, -1, 1, "R6", 1);
    // R3: disabled, illegal sizes, non-linear ordering
    en = 1'b0;
    scen(32'h280, 16, -1, 1, "R3", 1);
    en = 1'b1; cls = 8'd6;
    scen(32'h2C0, 16, -1, 1, "R3", 1);
    cls = 8'd32;
    scen(32'h300, 32, -1, 1, "R3", 1);
    cls = 8'd8;
    scen(32'h340, 16, -1, 0, "R3", 1);
    // R8: burst ends inside its second line
    scen(32'h380, 12, -1, 1, "R8", 2);
    // R7: disconnect inside line 0x408
    disc_on = 1; disc_at = 32'h40A;
    scen(32'h400, 24, -1, 1, "R7", 3);
    // R11: disconnect on the last beat of the first line
    disc_on = 1; disc_at = 32'h507;
    scen(32'h500, 16, -1, 1, "R11", 2);
    // R9: latency expiry mid-line inside a promoted run
    lat_on = 1; lat_at = 32'h602;
    scen(32'h600, 16, -1, 1, "R9", 2);
    // R10: latency expiry during a plain-write run
    en = 1'b0; lat_on = 1; lat_at = 32'h703;
    scen(32'h700, 8, -1, 1, "R10", 2);
    en = 1'b1;

    // R2: random bursts, sizes, holes, ordering and events
    rand_ev = 1;
    for (int k = 0; k < 150; k++) begin
      int pick, n, hole;
      pick = $urandom_range(0, 4);
      cls  = (pick == 0) ? 8'd4 : (pick == 1) ? 8'd16 : (pick == 2) ? 8'd6 : 8'd8;
      en   = ($urandom_range(0, 99) < 85);
      n    = $urandom_range(1, 40);
      hole = ($urandom_range(0, 99) < 30) ? $urandom_range(0, n - 1) : -1;
      send(32'h1000 + 32'($urandom_range(0, 4000)), n, hole,
           ($urandom_range(0, 99) < 90), "R2");
      drain();
    end
    check(q.size() == 0, "R2", "leftover expected beats", q.size(), 0);
    finished = 1;
    finish_run();
  end
endmodule